// File: doc/BRIEF.md
# Indirect Register Port for a Video Output Stage

This block is the processor-facing register port of a video output stage. A host drives an 8-bit data bus, a two-bit select field, a read/write flag and an access strobe. The two pointer selects load or return one byte of a 16-bit address pointer. The data select then reaches whatever the pointer currently names. Data accesses leave the pointer unchanged, so a host loads the pointer once and may read or write the same location several times.

The low 11 bits of the pointer are decoded. Bits 15 to 11 are stored and can be read back, but they do not affect decoding. Pointer values 000h to 3FFh name palette locations. These accesses are passed on to an external palette memory through a separate address, write-data, write-enable and read-enable port. Above the palette region there is a sparse set of control registers: a display command register, a second command register and three per-channel gain-error trim registers. Every other location is reserved. The fields of the display command register drive dedicated output pins.

Read data is combinational. `bus_rdata_o` shows the addressed byte while a read strobe is active, and it is 00h at all other times.

Top module: `mpu_reg_port`

## Requirements
- R1: After reset the pointer, both command registers and the three gain registers are zero, and every mode output is low.
- R2: With the strobe high, a write with select 00 loads pointer bits 7:0 and a write with select 01 loads pointer bits 15:8. The other byte keeps its value.
- R3: With the strobe high, a read with select 00 returns pointer bits 7:0 and a read with select 01 returns pointer bits 15:8.
- R4: A select 10 access whose pointer bits 10:0 fall in 000h–3FFh goes to the palette port with `pal_addr_o` equal to pointer bits 9:0. A write pulses `pal_we_o` with `pal_wdata_o` equal to the bus data. A read returns `pal_rdata_i`.
- R5: Location 400h is the display command register, which can be read and written. Its bits drive the outputs as follows: bit 7 drives `interlace_o`, bit 5 drives `pedestal_o` (1 selects 7.5 IRE), bit 4 drives `sync_en_o[2]` (red), bit 3 drives `sync_en_o[1]` (green), bit 2 drives `sync_en_o[0]` (blue), bit 1 drives `inv_sync_o` and bit 0 drives `inv_blank_o`. Bit 6 is stored and read back but drives no output.
- R6: Locations 40Bh, 40Ch and 40Dh hold the red, green and blue gain-error registers, and location 410h holds the second command register. All four can be read and written, and each drives its own output.
- R7: Every other location from 401h to 7FFh is reserved. A write to it changes no register and makes no palette access, and a read from it returns 00h.
- R8: Select 11 is reserved. A write with select 11 changes nothing, and a read with select 11 returns 00h.
- R9: A select 10 access, read or write, leaves the pointer unchanged.
- R10: Pointer bits 15:11 take no part in decoding. For example, pointer FC00h reaches the display command register.
- R11: `bus_rdata_o` is 00h whenever no read strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cs_i | input | 1 | Access strobe |
| bus_sel_i | input | 2 | Select: 00 pointer low, 01 pointer high, 10 data, 11 reserved |
| bus_rd_i | input | 1 | 1 selects a read, 0 selects a write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| pal_addr_o | output | 10 | Palette address |
| pal_wdata_o | output | 8 | Palette write data |
| pal_we_o | output | 1 | Palette write enable |
| pal_re_o | output | 1 | Palette read enable |
| pal_rdata_i | input | 8 | Palette read data, combinational |
| interlace_o | output | 1 | Interlaced display selected |
| pedestal_o | output | 1 | 7.5 IRE pedestal selected |
| sync_en_o | output | 3 | Sync decode enables, {red, green, blue} |
| inv_sync_o | output | 1 | Sync on inverted outputs |
| inv_blank_o | output | 1 | Blank on inverted outputs |
| cmd2_o | output | 8 | Second command register |
| gain_r_o | output | 8 | Red gain-error register |
| gain_g_o | output | 8 | Green gain-error register |
| gain_b_o | output | 8 | Blue gain-error register |

## Verification
The pointer is hidden inside the block. If its state goes wrong, the next pointer readback shows a wrong byte within the same cycle. A wrong pointer also sends the following data access to the wrong place: the palette port shows a wrong address or an unexpected write pulse, or a register readback returns the wrong value. A decode fault lets a reserved-location write reach a register. This shows on the mode or gain outputs one cycle after the write. It also shows as a changed palette byte when the palette location that shares the same ten low pointer bits is read later. The bench therefore follows every disallowed write with both output checks and readbacks.

// File: rtl/mpu_reg_pkg.sv
package mpu_reg_pkg;

  localparam int unsigned MAP_W = 11;

  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'b00,
    SEL_PTR_HI = 2'b01,
    SEL_DATA   = 2'b10,
    SEL_RSVD   = 2'b11
  } sel_e;

  typedef enum logic [2:0] {
    TGT_PAL,
    TGT_CMD1,
    TGT_CMD2,
    TGT_GAIN_R,
    TGT_GAIN_G,
    TGT_GAIN_B,
    TGT_NONE
  } tgt_e;

  localparam logic [MAP_W-1:0] ADR_CMD1   = 11'h400;
  localparam logic [MAP_W-1:0] ADR_GAIN_R = 11'h40B;
  localparam logic [MAP_W-1:0] ADR_GAIN_G = 11'h40C;
  localparam logic [MAP_W-1:0] ADR_GAIN_B = 11'h40D;
  localparam logic [MAP_W-1:0] ADR_CMD2   = 11'h410;

  localparam tgt_e GAIN_TGT [3] = '{TGT_GAIN_R, TGT_GAIN_G, TGT_GAIN_B};

  typedef struct packed {
    logic ptr_lo_we;
    logic ptr_hi_we;
    logic ptr_lo_re;
    logic ptr_hi_re;
    logic data_we;
    logic data_re;
  } acc_t;

endpackage

// File: rtl/mpu_bus_decode.sv
module mpu_bus_decode
  import mpu_reg_pkg::*;
(
  input  logic       cs_i,
  input  logic       rd_i,
  input  logic [1:0] sel_i,
  output acc_t       acc_o
);
  sel_e sel;
  logic wr, rd;

  assign sel = sel_e'(sel_i);
  assign wr  = cs_i & ~rd_i;
  assign rd  = cs_i & rd_i;

  always_comb begin
    acc_o = '0;
    unique case (sel)
      SEL_PTR_LO: begin acc_o.ptr_lo_we = wr; acc_o.ptr_lo_re = rd; end
      SEL_PTR_HI: begin acc_o.ptr_hi_we = wr; acc_o.ptr_hi_re = rd; end
      SEL_DATA:   begin acc_o.data_we   = wr; acc_o.data_re   = rd; end
      default:    acc_o = '0; // reserved select: no effect
    endcase
  end
endmodule

// File: rtl/mpu_addr_ptr.sv
module mpu_addr_ptr #(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int unsigned HI_W = PTR_W - DW;

  logic [DW-1:0]   lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_q <= '0;
    else if (lo_we_i) lo_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (hi_we_i) hi_q <= wdata_i[HI_W-1:0];
  end

  assign ptr_o = {hi_q, lo_q};
endmodule

// File: rtl/mpu_addr_map.sv
module mpu_addr_map
  import mpu_reg_pkg::*;
#(
  parameter int unsigned PAL_AW = 10
) (
  input  logic [MAP_W-1:0] addr_i,
  output tgt_e             tgt_o
);
  logic in_pal;
  assign in_pal = (addr_i >> PAL_AW) == '0;

  always_comb begin
    if (in_pal) tgt_o = TGT_PAL;
    else begin
      unique case (addr_i)
        ADR_CMD1:   tgt_o = TGT_CMD1;
        ADR_CMD2:   tgt_o = TGT_CMD2;
        ADR_GAIN_R: tgt_o = TGT_GAIN_R;
        ADR_GAIN_G: tgt_o = TGT_GAIN_G;
        ADR_GAIN_B: tgt_o = TGT_GAIN_B;
        default:    tgt_o = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mpu_ctrl_regs.sv
module mpu_ctrl_regs
  import mpu_reg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  tgt_e              tgt_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     cmd1_o,
  output logic [DW-1:0]     cmd2_o,
  output logic [2:0][DW-1:0] gain_o,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] cmd1_q, cmd2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cmd1_q <= '0;
    else if (we_i && tgt_i == TGT_CMD1)  cmd1_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cmd2_q <= '0;
    else if (we_i && tgt_i == TGT_CMD2)  cmd2_q <= wdata_i;
  end

  for (genvar g = 0; g < 3; g++) begin : g_gain
    logic [DW-1:0] gain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            gain_q <= '0;
      else if (we_i && tgt_i == GAIN_TGT[g])  gain_q <= wdata_i;
    end
    assign gain_o[g] = gain_q;
  end

  always_comb begin
    unique case (tgt_i)
      TGT_CMD1:   rdata_o = cmd1_q;
      TGT_CMD2:   rdata_o = cmd2_q;
      TGT_GAIN_R: rdata_o = gain_o[0];
      TGT_GAIN_G: rdata_o = gain_o[1];
      TGT_GAIN_B: rdata_o = gain_o[2];
      default:    rdata_o = '0;
    endcase
  end

  assign cmd1_o = cmd1_q;
  assign cmd2_o = cmd2_q;
endmodule

// File: rtl/mpu_reg_port.sv
module mpu_reg_port
  import mpu_reg_pkg::*;
#(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned PAL_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_cs_i,
  input  logic [1:0]        bus_sel_i,
  input  logic              bus_rd_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [PAL_AW-1:0] pal_addr_o,
  output logic [DW-1:0]     pal_wdata_o,
  output logic              pal_we_o,
  output logic              pal_re_o,
  input  logic [DW-1:0]     pal_rdata_i,
  output logic              interlace_o,
  output logic              pedestal_o,
  output logic [2:0]        sync_en_o,
  output logic              inv_sync_o,
  output logic              inv_blank_o,
  output logic [DW-1:0]     cmd2_o,
  output logic [DW-1:0]     gain_r_o,
  output logic [DW-1:0]     gain_g_o,
  output logic [DW-1:0]     gain_b_o
);
  acc_t               acc;
  logic [PTR_W-1:0]   ptr_q;
  tgt_e               tgt;
  logic [DW-1:0]      cmd1_q;
  logic [DW-1:0]      reg_rdata;
  logic [2:0][DW-1:0] gain;
  logic               is_pal;

  mpu_bus_decode u_dec (
    .cs_i  (bus_cs_i),
    .rd_i  (bus_rd_i),
    .sel_i (bus_sel_i),
    .acc_o (acc)
  );

  mpu_addr_ptr #(.PTR_W(PTR_W), .DW(DW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_we_i (acc.ptr_lo_we),
    .hi_we_i (acc.ptr_hi_we),
    .wdata_i (bus_wdata_i),
    .ptr_o   (ptr_q)
  );

  mpu_addr_map #(.PAL_AW(PAL_AW)) u_map (
    .addr_i (ptr_q[MAP_W-1:0]),
    .tgt_o  (tgt)
  );

  assign is_pal = (tgt == TGT_PAL);

  mpu_ctrl_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (acc.data_we & ~is_pal),
    .tgt_i   (tgt),
    .wdata_i (bus_wdata_i),
    .cmd1_o  (cmd1_q),
    .cmd2_o  (cmd2_o),
    .gain_o  (gain),
    .rdata_o (reg_rdata)
  );

  assign pal_addr_o  = ptr_q[PAL_AW-1:0];
  assign pal_wdata_o = bus_wdata_i;
  assign pal_we_o    = acc.data_we & is_pal;
  assign pal_re_o    = acc.data_re & is_pal;

  always_comb begin
    bus_rdata_o = '0;
    if (acc.ptr_lo_re)      bus_rdata_o = ptr_q[DW-1:0];
    else if (acc.ptr_hi_re) bus_rdata_o = ptr_q[PTR_W-1:DW];
    else if (acc.data_re)   bus_rdata_o = is_pal ? pal_rdata_i : reg_rdata;
  end

  // display command fields; bit 6 is storage only
  assign interlace_o = cmd1_q[7];
  assign pedestal_o  = cmd1_q[5];
  assign sync_en_o   = cmd1_q[4:2];
  assign inv_sync_o  = cmd1_q[1];
  assign inv_blank_o = cmd1_q[0];

  assign gain_r_o = gain[0];
  assign gain_g_o = gain[1];
  assign gain_b_o = gain[2];
endmodule

// File: rtl/mpu_reg_port_chk.sv
module mpu_reg_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_cs_i,
  input logic [1:0]  bus_sel_i,
  input logic        bus_rd_i,
  input logic [7:0]  bus_wdata_i,
  input logic [7:0]  bus_rdata_o,
  input logic [9:0]  pal_addr_o,
  input logic        pal_we_o,
  input logic        pal_re_o,
  input logic        interlace_o,
  input logic        pedestal_o,
  input logic [2:0]  sync_en_o,
  input logic [7:0]  cmd2_o,
  input logic [7:0]  gain_r_o,
  input logic [7:0]  gain_g_o,
  input logic [7:0]  gain_b_o,
  input logic [15:0] ptr_q,
  input logic [7:0]  cmd1_q
);
  logic [10:0] a;
  logic        rsvd_loc;
  assign a = ptr_q[10:0];
  assign rsvd_loc = a[10] && a != 11'h400 && a != 11'h40B && a != 11'h40C
                    && a != 11'h40D && a != 11'h410;

  p_lo_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_i && !bus_rd_i && bus_sel_i == 2'b00 |=>
      ptr_q[7:0] == $past(bus_wdata_i) && ptr_q[15:8] == $past(ptr_q[15:8]));

  p_hi_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_i && !bus_rd_i && bus_sel_i == 2'b01 |=>
      ptr_q[15:8] == $past(bus_wdata_i) && ptr_q[7:0] == $past(ptr_q[7:0]));

  p_pal_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we_o |-> bus_cs_i && !bus_rd_i && bus_sel_i == 2'b10 && !ptr_q[10]
                 && pal_addr_o == ptr_q[9:0]);

  p_cmd1_fields_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_i && !bus_rd_i && bus_sel_i == 2'b10 && a == 11'h400 |=>
      interlace_o == $past(bus_wdata_i[7]) && pedestal_o == $past(bus_wdata_i[5])
      && sync_en_o == $past(bus_wdata_i[4:2]));

  p_rsvd_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_i && bus_rd_i && bus_sel_i == 2'b10 && rsvd_loc |->
      bus_rdata_o == 8'h00 && !pal_re_o);

  p_rsvd_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_i && !bus_rd_i && bus_sel_i == 2'b10 && rsvd_loc |=>
      $stable({cmd1_q, cmd2_o, gain_r_o, gain_g_o, gain_b_o}));

  p_sel_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_i && bus_sel_i == 2'b11 |->
      bus_rdata_o == 8'h00 && !pal_we_o && !pal_re_o);

  p_ptr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_i && bus_sel_i[1] |=> ptr_q == $past(ptr_q));

  p_idle_rdata_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_cs_i && bus_rd_i) |-> bus_rdata_o == 8'h00);
endmodule

bind mpu_reg_port mpu_reg_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_cs_i    (bus_cs_i),
  .bus_sel_i   (bus_sel_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pal_addr_o  (pal_addr_o),
  .pal_we_o    (pal_we_o),
  .pal_re_o    (pal_re_o),
  .interlace_o (interlace_o),
  .pedestal_o  (pedestal_o),
  .sync_en_o   (sync_en_o),
  .cmd2_o      (cmd2_o),
  .gain_r_o    (gain_r_o),
  .gain_g_o    (gain_g_o),
  .gain_b_o    (gain_b_o),
  .ptr_q       (ptr_q),
  .cmd1_q      (cmd1_q)
);

// File: tb/mpu_reg_port_test.sv
module mpu_reg_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cs, rd;
  logic [1:0] sel;
  logic [7:0] wd, rdata;
  logic [9:0] pal_addr;
  logic [7:0] pal_wdata, pal_rdata;
  logic       pal_we, pal_re;
  logic       interlace, pedestal, inv_sync, inv_blank;
  logic [2:0] sync_en;
  logic [7:0] cmd2, gain_r, gain_g, gain_b;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] pal_mem [1024];

  always #10 clk_i = ~clk_i;

  mpu_reg_port uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_cs_i(cs), .bus_sel_i(sel), .bus_rd_i(rd),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .pal_addr_o(pal_addr), .pal_wdata_o(pal_wdata),
    .pal_we_o(pal_we), .pal_re_o(pal_re), .pal_rdata_i(pal_rdata),
    .interlace_o(interlace), .pedestal_o(pedestal), .sync_en_o(sync_en),
    .inv_sync_o(inv_sync), .inv_blank_o(inv_blank), .cmd2_o(cmd2),
    .gain_r_o(gain_r), .gain_g_o(gain_g), .gain_b_o(gain_b)
  );

  // palette memory model
  initial for (int i = 0; i < 1024; i++) pal_mem[i] = 8'h00;
  always @(posedge clk_i) if (pal_we) pal_mem[pal_addr] <= pal_wdata;
  assign pal_rdata = pal_mem[pal_addr];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data while a read strobe is active
  always @(negedge clk_i) begin
    if (rst_ni && cs && rd) begin
      if (exp_q.size() == 0) chk("R11 unexpected read", {8'h0, rdata}, 16'hFFFF);
      else chk(tag_q.pop_front(), {8'h0, rdata}, {8'h0, exp_q.pop_front()});
    end
  end

  task automatic bus(input logic [1:0] s, input logic r, input logic [7:0] d);
    @(posedge clk_i); #1;
    cs = 1'b1; sel = s; rd = r; wd = d;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    bus(s, 1'b0, d);
  endtask

  task automatic rd_exp(input logic [1:0] s, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus(s, 1'b1, 8'h00);
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr(2'b00, p[7:0]);
    wr(2'b01, p[15:8]);
  endtask

  task automatic settle();
    @(posedge clk_i); #1;
    cs = 1'b0; rd = 1'b0; sel = 2'b00; wd = 8'h00;
    @(negedge clk_i);
  endtask

  task automatic chk_cmd1(input string tag, input logic [7:0] v);
    chk({tag, " interlace"}, {15'h0, interlace}, {15'h0, v[7]});
    chk({tag, " pedestal"},  {15'h0, pedestal},  {15'h0, v[5]});
    chk({tag, " sync_en"},   {13'h0, sync_en},   {13'h0, v[4:2]});
    chk({tag, " inv_sync"},  {15'h0, inv_sync},  {15'h0, v[1]});
    chk({tag, " inv_blank"}, {15'h0, inv_blank}, {15'h0, v[0]});
  endtask

  task automatic chk_regs(input string tag, input logic [7:0] c2, input logic [7:0] r,
                          input logic [7:0] g, input logic [7:0] b);
    chk({tag, " cmd2"},   {8'h0, cmd2},   {8'h0, c2});
    chk({tag, " gain_r"}, {8'h0, gain_r}, {8'h0, r});
    chk({tag, " gain_g"}, {8'h0, gain_g}, {8'h0, g});
    chk({tag, " gain_b"}, {8'h0, gain_b}, {8'h0, b});
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_ni = 1'b0; cs = 1'b0; rd = 1'b0; sel = 2'b00; wd = 8'h00;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk_cmd1("R1", 8'h00);
    chk_regs("R1", 8'h00, 8'h00, 8'h00, 8'h00);
    rd_exp(2'b00, 8'h00, "R1 ptr lo");
    rd_exp(2'b01, 8'h00, "R1 ptr hi");
    set_ptr(16'h0400);
    rd_exp(2'b10, 8'h00, "R1 cmd1");
    settle();
    chk("R11 idle rdata", {8'h0, rdata}, 16'h0000);

    // R2 / R3 byte-wise pointer load and readback
    wr(2'b00, 8'h34);
    rd_exp(2'b00, 8'h34, "R2 lo load");
    rd_exp(2'b01, 8'h04, "R2 hi kept");
    wr(2'b01, 8'h12);
    rd_exp(2'b01, 8'h12, "R3 hi read");
    rd_exp(2'b00, 8'h34, "R3 lo kept");

    // R4 palette region, R9 pointer hold
    set_ptr(16'h0005);
    wr(2'b10, 8'h11);
    rd_exp(2'b10, 8'h11, "R4 pal 005");
    set_ptr(16'h03FF);
    wr(2'b10, 8'hA5);
    rd_exp(2'b10, 8'hA5, "R4 pal 3FF");
    rd_exp(2'b00, 8'hFF, "R9 ptr lo after data");
    rd_exp(2'b01, 8'h03, "R9 ptr hi after data");
    settle();
    chk("R4 pal mem 3FF", {8'h0, pal_mem[10'h3FF]}, 16'h00A5);

    // R5 display command register
    set_ptr(16'h0400);
    wr(2'b10, 8'hFF);
    settle();
    chk_cmd1("R5 FF", 8'hFF);
    wr(2'b10, 8'hA5);
    rd_exp(2'b10, 8'hA5, "R5 read A5");
    settle();
    chk_cmd1("R5 A5", 8'hA5);
    wr(2'b10, 8'h40);
    rd_exp(2'b10, 8'h40, "R5 bit6 read");
    settle();
    chk_cmd1("R5 bit6 only", 8'h40);

    // R6 gain and second command registers
    set_ptr(16'h040B); wr(2'b10, 8'h1B);
    set_ptr(16'h040C); wr(2'b10, 8'h2C);
    set_ptr(16'h040D); wr(2'b10, 8'h3D);
    set_ptr(16'h0410); wr(2'b10, 8'h77);
    settle();
    chk_regs("R6", 8'h77, 8'h1B, 8'h2C, 8'h3D);
    set_ptr(16'h040B); rd_exp(2'b10, 8'h1B, "R6 read gain r");
    set_ptr(16'h040C); rd_exp(2'b10, 8'h2C, "R6 read gain g");
    set_ptr(16'h040D); rd_exp(2'b10, 8'h3D, "R6 read gain b");
    set_ptr(16'h0410); rd_exp(2'b10, 8'h77, "R6 read cmd2");

    // R7 reserved locations
    set_ptr(16'h0405);
    wr(2'b10, 8'hEE);
    rd_exp(2'b10, 8'h00, "R7 read 405");
    set_ptr(16'h0005);
    rd_exp(2'b10, 8'h11, "R7 pal 005 untouched");
    set_ptr(16'h04FF);
    wr(2'b10, 8'h55);
    rd_exp(2'b10, 8'h00, "R7 read 4FF");
    set_ptr(16'h0600);
    wr(2'b10, 8'h66);
    rd_exp(2'b10, 8'h00, "R7 read 600");
    settle();
    chk_regs("R7", 8'h77, 8'h1B, 8'h2C, 8'h3D);
    chk_cmd1("R7", 8'h40);
    chk("R7 pal 200 untouched", {8'h0, pal_mem[10'h200]}, 16'h0000);

    // R8 reserved select
    wr(2'b11, 8'h99);
    rd_exp(2'b11, 8'h00, "R8 read sel11");
    rd_exp(2'b00, 8'h00, "R8 ptr lo kept");
    rd_exp(2'b01, 8'h06, "R8 ptr hi kept");
    settle();
    chk_regs("R8", 8'h77, 8'h1B, 8'h2C, 8'h3D);
    chk_cmd1("R8", 8'h40);

    // R10 upper pointer bits ignored in decode
    set_ptr(16'hFC00);
    rd_exp(2'b10, 8'h40, "R10 alias cmd1");
    rd_exp(2'b01, 8'hFC, "R10 hi readback");
    wr(2'b10, 8'h81);
    settle();
    chk_cmd1("R10 alias write", 8'h81);
    chk("R11 idle rdata end", {8'h0, rdata}, 16'h0000);
    chk("R11 queue drained", exp_q.size()[15:0], 16'h0000);

    summary();
  end
endmodule